// File: doc/BRIEF.md
# Retransmitting Link Sender

This block drives one direction of a point-to-point link between two on-chip routers. Flits come in from upstream through a valid/ready handshake. Each accepted flit goes into a small replay store, and the block places it on the link with a valid strobe. The flit stays in the store until the far end accepts it.

The receiver answers each flit in order, at most one answer per cycle. It answers with an accept pulse or with a refusal pulse. A refusal means the flit was damaged or the receiver had no room for it. After a refusal the sender discards everything it has sent since the refused flit. It rewinds its send position to the oldest flit still waiting for an answer and starts sending again from there, in order. When the store holds as many waiting flits as it has slots, the upstream handshake stalls.

Top module: `lnk_retx_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `lnk_vld` is 0 and `up_rdy` is 1.
- R2: A flit is accepted on a clock edge where `up_vld` and `up_rdy` are both 1. Accepted flits appear on `lnk_dat` with `lnk_vld` = 1 in the order they were accepted, at most one per cycle.
- R3: The replay store holds DEPTH (default 8) unanswered flits. While DEPTH flits are unanswered, `up_rdy` is 0 and no upstream flit is accepted.
- R4: An accept pulse on `lnk_ack` retires the oldest unanswered flit and frees its slot. `up_rdy` is 1 in the cycle after any accept pulse.
- R5: A refusal pulse on `lnk_nack` refers to the oldest unanswered flit. In the next cycle `lnk_vld` is 1 and `lnk_dat` carries that refused flit. The flits after it follow again in their original order.
- R6: `lnk_ack` and `lnk_nack` must never be 1 in the same cycle. The design flags this as an assertion error.
- R7: An accept or refusal pulse arrives only while at least one sent flit is unanswered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_vld | input | 1 | Upstream flit present |
| up_dat | input | W | Upstream flit data |
| up_rdy | output | 1 | Sender can take a flit |
| lnk_vld | output | 1 | Flit on the link is valid |
| lnk_dat | output | W | Link flit data |
| lnk_ack | input | 1 | Receiver accepted the oldest unanswered flit |
| lnk_nack | input | 1 | Receiver refused the oldest unanswered flit |

## Verification
The sender is tried against a receiver model that answers one cycle after each flit and ignores the flit that is in flight when it refuses. Three patterns are used:
- A clean stream, where every flit is accepted. This separates correct ordering from duplication or loss.
- Injected corruption on chosen flits. After each refusal the next link flit is compared with the refused one, so a missing or misplaced rewind shows up.
- A stalled receiver buffer that refuses everything. This drives the store to full: the count of accepted upstream flits must stop at exactly the acknowledged flits plus DEPTH, and the stream must then finish in order once draining resumes.

// File: rtl/lnk_retx_tx.sv
module lnk_retx_tx #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_vld,
  input  logic [W-1:0] up_dat,
  output logic         up_rdy,
  output logic         lnk_vld,
  output logic [W-1:0] lnk_dat,
  input  logic         lnk_ack,
  input  logic         lnk_nack
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_p, snd_p, ack_p;
  logic [AW:0]  used;
  logic         take;

  assign used    = wr_p - ack_p;
  assign up_rdy  = used < FULL;
  assign take    = up_vld && up_rdy;
  assign lnk_vld = snd_p != wr_p;
  assign lnk_dat = mem[snd_p[AW-1:0]];

  always_ff @(posedge clk) begin
    if (take) mem[wr_p[AW-1:0]] <= up_dat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p  <= '0;
      snd_p <= '0;
      ack_p <= '0;
    end else begin
      if (take) wr_p <= wr_p + 1'b1;
      if (lnk_ack) ack_p <= ack_p + 1'b1;
      if (lnk_nack) snd_p <= ack_p;
      else if (lnk_vld) snd_p <= snd_p + 1'b1;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_ack && lnk_nack)); // R6
  AST_RESP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_ack || lnk_nack) |-> (snd_p != ack_p)); // R7
  AST_REPLAY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_nack |=> lnk_vld); // R5
  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ack |=> up_rdy); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= FULL); // R3
endmodule

// File: tb/lnk_retx_tx_bench.sv
module lnk_retx_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int RXCAP = 2;
  localparam int LIMIT = 20000;

  logic clk = 0, rst_n = 0;
  logic up_vld = 0;
  logic [W-1:0] up_dat = '0;
  logic up_rdy, lnk_vld;
  logic [W-1:0] lnk_dat;
  logic lnk_ack = 0, lnk_nack = 0;

  int checks = 0, fails = 0, cycles = 0, accepted = 0, nacks = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] rx_q[$];
  bit drain_en = 1, corrupt_pend = 0;
  bit pend_ack = 0, pend_nack = 0, replay_due = 0;
  logic [W-1:0] pend_dat = '0, replay_dat = '0;

  lnk_retx_tx #(.W(W), .DEPTH(8)) u_lnk_retx_tx (
    .clk(clk), .rst_n(rst_n), .up_vld(up_vld), .up_dat(up_dat), .up_rdy(up_rdy),
    .lnk_vld(lnk_vld), .lnk_dat(lnk_dat), .lnk_ack(lnk_ack), .lnk_nack(lnk_nack));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      check(0, "watchdog", cycles, LIMIT);
      finish_run();
    end
  end

  // Receiver model with one-cycle answer latency; it answers only flits it has seen (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (replay_due) begin
        check(lnk_vld && lnk_dat == replay_dat, "R5 replay", int'(lnk_dat), int'(replay_dat));
        replay_due = 0;
      end
      if (drain_en && rx_q.size() > 0) begin
        logic [W-1:0] got, want;
        got = rx_q.pop_front();
        want = (exp_q.size() > 0) ? exp_q.pop_front() : ~got;
        check(got == want, "R2 order", int'(got), int'(want));
      end
      lnk_ack  = pend_ack;
      lnk_nack = pend_nack;
      if (pend_nack) begin
        replay_due = 1;
        replay_dat = pend_dat;
        nacks++;
      end
      if (lnk_ack && lnk_nack) check(0, "R6 both", 1, 0);
      pend_ack = 0;
      pend_nack = 0;
      if (lnk_vld && !lnk_nack) begin
        pend_dat = lnk_dat;
        if (corrupt_pend || rx_q.size() >= RXCAP) begin
          pend_nack = 1;
          corrupt_pend = 0;
        end else begin
          rx_q.push_back(lnk_dat);
          pend_ack = 1;
        end
      end
    end
  end

  task automatic push(input logic [W-1:0] d);
    up_vld = 1;
    up_dat = d;
    forever begin
      if (up_rdy) begin
        exp_q.push_back(d);
        accepted++;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    up_vld = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0 || rx_q.size() > 0 || lnk_vld) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lnk_vld == 0, "R1 vld in reset", lnk_vld, 0);
    check(up_rdy == 1, "R1 rdy in reset", up_rdy, 1);
    rst_n = 1;
    @(negedge clk);
    check(lnk_vld == 0, "R1 vld after reset", lnk_vld, 0);
    check(up_rdy == 1, "R1 rdy after reset", up_rdy, 1);

    // clean stream
    for (int i = 0; i < 20; i++) push(W'(16'h100 + i));
    wait_idle();
    check(up_rdy == 1 && lnk_vld == 0, "R4 idle after stream", up_rdy, 1);

    // injected corruption
    fork
      for (int i = 0; i < 24; i++) push(W'(16'h200 + i));
      begin
        repeat (4) @(negedge clk); corrupt_pend = 1;
        repeat (9) @(negedge clk); corrupt_pend = 1;
        repeat (2) @(negedge clk); corrupt_pend = 1;
      end
    join
    wait_idle();
    check(nacks >= 3, "R5 refusals seen", nacks, 3);

    // stalled receiver fills the replay store
    drain_en = 0;
    accepted = 0;
    fork
      for (int i = 0; i < 14; i++) push(W'(16'h300 + i));
    join_none
    repeat (60) @(negedge clk);
    check(up_rdy == 0, "R3 rdy low when full", up_rdy, 0);
    check(accepted == RXCAP + 8, "R3 accepted count", accepted, RXCAP + 8);
    repeat (20) @(negedge clk);
    check(accepted == RXCAP + 8, "R3 nothing taken while full", accepted, RXCAP + 8);
    drain_en = 1;
    wait fork;
    wait_idle();
    check(accepted == 14, "R4 store frees after drain", accepted, 14);
    check(up_rdy == 1 && lnk_vld == 0, "R4 idle after drain", up_rdy, 1);
    finish_run();
  end
endmodule